// File: doc/BRIEF.md
# Opcode-Menu SPI Command Sequencer

This block is a software-driven SPI master that runs one flash command each time software writes a start request. Software does not hand over a raw opcode. It picks one of eight entries in a programmable opcode menu, and a 2-bit type code for each entry says two things: whether the command carries a 24-bit address, and whether its data phase reads or writes. A 64-byte buffer supplies write data and collects read data. On request, a prefix opcode such as write-enable goes out first in its own chip-select frame. The selected command follows straight after, and the bus stays claimed across both frames.

Software programs the menu, the type word and the prefix once. It can then freeze them with a sticky lock bit. For each command it writes the address and any write data, writes the control word, and polls the status word for done or error.

Top module: `spi_menu_seq`

## Requirements
- R1: After reset the status word reads 0, chip select is high, the serial clock is low and the bus-claim output is low.
- R2: The opcode sent is the menu byte chosen by control bits 6:4. Menu entries 0-3 sit in word 5 and entries 4-7 in word 6, with entry n at bits 8(n mod 4)+7 : 8(n mod 4). The entry's type is taken from word 4 at bits 2n+1:2n.
- R3: Type codes: 0 is read with no address, 1 is write with no address, 2 is read with address, 3 is write with address. Type bit 1 adds an address phase, and type bit 0 selects write data over read data.
- R4: For address types, three address bytes follow the opcode, most significant first, taken from bits 23:0 of word 2. Bits 31:24 are never sent.
- R5: When control bit 14 is set, the data phase moves (bits 13:8)+1 bytes, from 1 up to 64, starting at buffer byte 0. Write types send buffer bytes. Read types send zeros and store the received bytes into the buffer. Buffer word w is at address 16+w, with byte 4w in bits 7:0.
- R6: When control bit 14 is clear, only the opcode goes out, plus the address for address types.
- R7: With control bit 2 set, the prefix opcode (word 3, bits 7:0) goes out first as a one-byte frame. Chip select then rises, and the command follows in a second frame. Bus-claim stays high from the first frame until the second frame has ended.
- R8: Status word 0 has busy at bit 0, done at bit 2 and error at bit 3. Busy is set while a command runs, and done is set when it ends. Writing 1 to bit 2 or bit 3 clears that bit.
- R9: A start request (control word 1, bit 1) arriving while busy sets the error bit. It leaves the running command's bytes unchanged and starts no further frame.
- R10: A start request that picks a read type (0 or 2) with bit 14 clear sets the error bit and sends nothing.
- R11: Writing 1 to status bit 15 sets a lock that only reset clears. While it is set, writes to the menu, type and prefix words have no effect. Address and buffer words stay writable.
- R12: The SPI line runs in mode 0, MSB first. The serial clock is high for exactly one clock per bit and stays low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Word address of the register access |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |
| busOwned | output | 1 | High while a command, including its prefix frame, holds the bus |

## Verification
A behavioural flash model records every frame and answers with a byte pattern tied to frame position. That lets the bench catch an address sent in the wrong byte order, which would show up as reversed address bytes. It also catches read data stored one slot off, which would return the wrong pattern value. The bench runs the 1-byte and 64-byte data limits, where a miscounted length field would add or drop a data byte. It runs the atomic prefix, where a design that dropped the bus between frames or merged both opcodes into one frame would show the wrong frame count inside the bus-claim window. It issues a start request during a running command, and separately a read type with no data phase; a faulty design would send an extra frame or corrupt the running one instead of raising error. Finally it writes the menu, type and prefix words after lockdown, where a leaky lock would change the readback and the opcode on the wire.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
  localparam int BUF_BYTES = 64;
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int BUF_AW    = $clog2(BUF_BYTES);
  localparam int REG_AW    = $clog2(BUF_WORDS) + 1;
  localparam int MENU_N    = 8;
  localparam int MENU_AW   = $clog2(MENU_N);

  localparam logic [REG_AW-1:0] A_STATUS = 0;
  localparam logic [REG_AW-1:0] A_CTRL   = 1;
  localparam logic [REG_AW-1:0] A_ADDR   = 2;
  localparam logic [REG_AW-1:0] A_PREFIX = 3;
  localparam logic [REG_AW-1:0] A_TYPES  = 4;
  localparam logic [REG_AW-1:0] A_MENULO = 5;
  localparam logic [REG_AW-1:0] A_MENUHI = 6;

  typedef enum logic [2:0] {
    SRC_PREFIX, SRC_OPCODE, SRC_ADDR, SRC_BUF, SRC_ZERO
  } byteSrc_e;

  typedef struct packed {
    logic              shiftGo;
    byteSrc_e          src;
    logic [1:0]        addrByte;
    logic [BUF_AW-1:0] bufIdx;
    logic [MENU_AW-1:0] menuIdx;
    logic              rxStore;
  } seqCmd_t;
endpackage

// File: rtl/spiseq_dp.sv
module spiseq_dp
  import spiseq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic                busy,
  input  logic                doneFlag,
  input  logic                errFlag,
  input  seqCmd_t             cmd,
  input  logic                spiMiso,
  output logic                spiMosi,
  output logic                spiSclk,
  output logic                byteDone,
  output logic [2*MENU_N-1:0] typeBits
);
  logic [MENU_N-1:0][7:0]    menuReg;
  logic [2*MENU_N-1:0]       typeReg;
  logic [7:0]                prefixReg;
  logic [31:0]               addrReg;
  logic                      lockReg;
  logic [BUF_BYTES-1:0][7:0] bufMem;
  logic [7:0] txByte, shReg, rxSh, rxByte;
  logic [2:0] bitCnt;
  logic       active, phase, sclkR;

  assign typeBits = typeReg;

  // register file and buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      menuReg   <= '0;
      typeReg   <= '0;
      prefixReg <= '0;
      addrReg   <= '0;
      lockReg   <= 1'b0;
      bufMem    <= '0;
    end else begin
      if (regWe) begin
        if (regAddr == A_STATUS && regWdata[15]) lockReg <= 1'b1;
        if (regAddr == A_ADDR) addrReg <= regWdata;
        if (!lockReg) begin
          if (regAddr == A_TYPES)  typeReg   <= regWdata[2*MENU_N-1:0];
          if (regAddr == A_PREFIX) prefixReg <= regWdata[7:0];
          for (int i = 0; i < 4; i++) begin
            if (regAddr == A_MENULO) menuReg[i]   <= regWdata[8*i +: 8];
            if (regAddr == A_MENUHI) menuReg[i+4] <= regWdata[8*i +: 8];
          end
        end
      end
      for (int i = 0; i < BUF_BYTES; i++) begin
        if (cmd.rxStore && cmd.bufIdx == BUF_AW'(i))
          bufMem[i] <= rxByte;
        else if (regWe && regAddr[REG_AW-1] && regAddr[REG_AW-2:0] == (REG_AW-1)'(i / 4))
          bufMem[i] <= regWdata[(i % 4)*8 +: 8];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr[REG_AW-1]) begin
      for (int b = 0; b < 4; b++)
        regRdata[8*b +: 8] = bufMem[{regAddr[REG_AW-2:0], 2'(b)}];
    end else begin
      unique case (regAddr)
        A_STATUS: regRdata = {16'd0, lockReg, 11'd0, errFlag, doneFlag, 1'b0, busy};
        A_ADDR:   regRdata = addrReg;
        A_PREFIX: regRdata = {24'd0, prefixReg};
        A_TYPES:  regRdata = {16'd0, typeReg};
        A_MENULO: regRdata = {menuReg[3], menuReg[2], menuReg[1], menuReg[0]};
        A_MENUHI: regRdata = {menuReg[7], menuReg[6], menuReg[5], menuReg[4]};
        default:  regRdata = '0;
      endcase
    end
  end

  // byte source selection
  always_comb begin
    unique case (cmd.src)
      SRC_PREFIX: txByte = prefixReg;
      SRC_OPCODE: txByte = menuReg[cmd.menuIdx];
      SRC_ADDR:   txByte = (cmd.addrByte == 2'd0) ? addrReg[23:16] :
                           (cmd.addrByte == 2'd1) ? addrReg[15:8] : addrReg[7:0];
      SRC_BUF:    txByte = bufMem[cmd.bufIdx];
      default:    txByte = 8'h00;
    endcase
  end

  // serial shifter: mode 0, MSB first, two clocks per bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0; rxSh <= '0; rxByte <= '0; bitCnt <= '0;
      active <= 1'b0; phase <= 1'b0; sclkR <= 1'b0; byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (!active) begin
        if (cmd.shiftGo) begin
          shReg <= txByte; active <= 1'b1; phase <= 1'b0; bitCnt <= '0;
        end
      end else if (!phase) begin
        sclkR <= 1'b1; phase <= 1'b1;
      end else begin
        sclkR  <= 1'b0; phase <= 1'b0;
        shReg  <= {shReg[6:0], 1'b0};
        rxSh   <= {rxSh[6:0], spiMiso};
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          active   <= 1'b0;
          byteDone <= 1'b1;
          rxByte   <= {rxSh[6:0], spiMiso};
        end
      end
    end
  end

  assign spiSclk = sclkR;
  assign spiMosi = active & shReg[7];

  p_sclk_one_cycle_r12: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |=> !spiSclk);
  p_lock_types_r11: assert property (@(posedge clk) disable iff (!rstN)
    (lockReg && regWe && regAddr == A_TYPES) |=> $stable(typeReg));
  p_lock_prefix_r11: assert property (@(posedge clk) disable iff (!rstN)
    (lockReg && regWe && regAddr == A_PREFIX) |=> $stable(prefixReg));
endmodule

// File: rtl/spiseq_ctl.sv
module spiseq_ctl
  import spiseq_pkg::*;
#(
  parameter int GAP_CYCLES = 2
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                goWr,
  input  logic                statWr,
  input  logic [31:0]         wdata,
  input  logic [2*MENU_N-1:0] typeBits,
  input  logic                byteDone,
  output seqCmd_t             cmd,
  output logic                csN,
  output logic                busOwned,
  output logic                busy,
  output logic                doneFlag,
  output logic                errFlag
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_GAP, S_OPC, S_ADR, S_DAT, S_END} state_e;
  state_e state;

  logic [MENU_AW-1:0] idxLat;
  logic [BUF_AW-1:0]  cntLat, byteCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic withAddr, isWrite, dataEn, launched;
  logic goReq, conflict, byteState;
  logic [1:0] selType;

  assign goReq     = goWr && wdata[1];
  assign selType   = typeBits[{wdata[6:4], 1'b0} +: 2];
  assign conflict  = !selType[0] && !wdata[14];
  assign busy      = (state != S_IDLE);
  assign busOwned  = busy;
  assign byteState = (state == S_PRE) || (state == S_OPC) || (state == S_ADR) || (state == S_DAT);
  assign csN       = !byteState;

  always_comb begin
    cmd          = '0;
    cmd.shiftGo  = byteState && !launched;
    cmd.menuIdx  = idxLat;
    cmd.addrByte = byteCnt[1:0];
    cmd.bufIdx   = byteCnt;
    cmd.rxStore  = (state == S_DAT) && !isWrite && byteDone;
    unique case (state)
      S_PRE:   cmd.src = SRC_PREFIX;
      S_ADR:   cmd.src = SRC_ADDR;
      S_DAT:   cmd.src = isWrite ? SRC_BUF : SRC_ZERO;
      default: cmd.src = SRC_OPCODE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; idxLat <= '0; cntLat <= '0; byteCnt <= '0; gapCnt <= '0;
      withAddr <= 1'b0; isWrite <= 1'b0; dataEn <= 1'b0; launched <= 1'b0;
      doneFlag <= 1'b0; errFlag <= 1'b0;
    end else begin
      if (byteDone)         launched <= 1'b0;
      else if (cmd.shiftGo) launched <= 1'b1;
      if (statWr) begin
        if (wdata[2]) doneFlag <= 1'b0;
        if (wdata[3]) errFlag  <= 1'b0;
      end
      unique case (state)
        S_IDLE: if (goReq) begin
          if (conflict) errFlag <= 1'b1;
          else begin
            idxLat   <= wdata[6:4];
            cntLat   <= wdata[13:8];
            dataEn   <= wdata[14];
            withAddr <= selType[1];
            isWrite  <= selType[0];
            byteCnt  <= '0;
            state    <= wdata[2] ? S_PRE : S_OPC;
          end
        end
        S_PRE: if (byteDone) begin state <= S_GAP; gapCnt <= '0; end
        S_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapCnt == GAP_W'(GAP_CYCLES - 1)) state <= S_OPC;
        end
        S_OPC: if (byteDone) state <= withAddr ? S_ADR : (dataEn ? S_DAT : S_END);
        S_ADR: if (byteDone) begin
          if (byteCnt == BUF_AW'(2)) begin
            byteCnt <= '0;
            state   <= dataEn ? S_DAT : S_END;
          end else byteCnt <= byteCnt + 1'b1;
        end
        S_DAT: if (byteDone) begin
          if (byteCnt == cntLat) state <= S_END;
          else byteCnt <= byteCnt + 1'b1;
        end
        default: begin doneFlag <= 1'b1; state <= S_IDLE; end
      endcase
      if (goReq && busy) errFlag <= 1'b1;
    end
  end

  p_go_busy_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (goReq && busy) |=> errFlag);
  p_conflict_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (goReq && !busy && conflict) |=> (!busy && errFlag));
  p_done_cs_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> csN);
  p_byte_in_frame_r12: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> byteState);
endmodule

// File: rtl/spi_menu_seq.sv
module spi_menu_seq
  import spiseq_pkg::*;
#(
  parameter int GAP_CYCLES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              busOwned
);
  seqCmd_t             cmd;
  logic                byteDone, busy, doneFlag, errFlag;
  logic [2*MENU_N-1:0] typeBits;

  spiseq_ctl #(.GAP_CYCLES(GAP_CYCLES)) uCtl (
    .clk(clk), .rstN(rstN),
    .goWr(regWe && regAddr == A_CTRL),
    .statWr(regWe && regAddr == A_STATUS),
    .wdata(regWdata), .typeBits(typeBits), .byteDone(byteDone),
    .cmd(cmd), .csN(spiCsN), .busOwned(busOwned),
    .busy(busy), .doneFlag(doneFlag), .errFlag(errFlag)
  );

  spiseq_dp uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .busy(busy), .doneFlag(doneFlag), .errFlag(errFlag),
    .cmd(cmd), .spiMiso(spiMiso), .spiMosi(spiMosi), .spiSclk(spiSclk),
    .byteDone(byteDone), .typeBits(typeBits)
  );
endmodule

// File: tb/sim_spi_menu_seq.sv
module sim_spi_menu_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic spiCsN, spiSclk, spiMosi, busOwned;
  logic spiMiso = 1'b0;

  int checks = 0, errors = 0, lineErr = 0;
  bit armed = 0, finished = 0;

  always #2 clk = ~clk;

  spi_menu_seq u0 (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .busOwned(busOwned));

  function automatic logic [7:0] fb(int p);
    return 8'((p * 37 + 90) & 255);
  endfunction

  // behavioural flash model
  int bitPos;
  logic [7:0] shIn;
  logic [7:0] curQ[$];
  logic [7:0] frameBytes[$];
  int frameLens[$];
  logic [7:0] expQ[$];

  always @(negedge spiCsN) if (armed) begin
    logic [7:0] t;
    bitPos = 0; shIn = 0; curQ.delete();
    t = fb(0); spiMiso = t[7];
  end
  always @(posedge spiSclk) if (armed && !spiCsN) begin
    shIn = {shIn[6:0], spiMosi};
    if (bitPos % 8 == 7) curQ.push_back(shIn);
  end
  always @(negedge spiSclk) if (armed && !spiCsN) begin
    logic [7:0] t;
    bitPos++;
    t = fb(bitPos / 8); spiMiso = t[7 - bitPos % 8];
  end
  always @(posedge spiCsN) if (armed) begin
    frameLens.push_back(curQ.size());
    foreach (curQ[i]) frameBytes.push_back(curQ[i]);
  end

  // per-clock line model and bus-claim window tracking
  logic prevSclk = 0, prevCs = 1, prevBus = 0;
  int winFrames = 0, lastWin = 0;
  always @(negedge clk) if (armed) begin
    if (spiSclk && prevSclk) lineErr++;
    if (spiCsN && spiSclk) lineErr++;
    if (!spiCsN && !busOwned) lineErr++;
    if (busOwned && spiCsN && !prevCs) winFrames++;
    if (prevBus && !busOwned) begin lastWin = winFrames; winFrames = 0; end
    prevSclk = spiSclk; prevCs = spiCsN; prevBus = busOwned;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    s = 0;
    while (!s[2]) rd(5'd0, s);
    wr(5'd0, 32'h4);
  endtask

  task automatic chkFrame(string req);
    int len, bad;
    logic [7:0] b, firstAct, firstExp;
    checks++; bad = 0; firstAct = 0; firstExp = 0;
    if (frameLens.size() == 0) begin
      errors++; $display("FAIL %s actual no frame expected %0d bytes", req, expQ.size());
      return;
    end
    len = frameLens.pop_front();
    if (len != expQ.size()) bad++;
    for (int i = 0; i < len; i++) begin
      b = frameBytes.pop_front();
      if (i < expQ.size() && b !== expQ[i] && bad == 0) begin
        bad++; firstAct = b; firstExp = expQ[i];
      end
    end
    if (bad != 0) begin
      errors++;
      $display("FAIL %s actual len %0d byte %h expected len %0d byte %h",
               req, len, firstAct, expQ.size(), firstExp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int bad;
    repeat (3) @(negedge clk);
    check("R1 csN", {31'd0, spiCsN}, 32'd1);
    check("R1 sclk", {31'd0, spiSclk}, 32'd0);
    check("R1 busOwned", {31'd0, busOwned}, 32'd0);
    rstN = 1; armed = 1;
    rd(5'd0, r); check("R1 status", r, 32'h0);

    // program menu, types and prefix
    wr(5'd5, 32'h20060203);
    wr(5'd6, 32'hC7AB059F);
    wr(5'd4, 32'h000050DE);
    wr(5'd3, 32'h00000006);

    // R2/R3: read-no-address id command, 3 data bytes
    wr(5'd1, 32'h2 | (4 << 4) | (2 << 8) | (1 << 14));
    rd(5'd0, r); check("R8 busy", r, 32'h1);
    waitDone();
    expQ = '{8'h9F, 8'h00, 8'h00, 8'h00}; chkFrame("R2 id frame");
    check("R7 single frame window", lastWin, 1);
    rd(5'd16, r); check("R5 read store", r[23:0], {fb(3), fb(2), fb(1)});
    rd(5'd0, r); check("R8 done cleared", r, 32'h0);

    // R4/R5/R7: atomic prefix + page write, 6 bytes
    wr(5'd16, 32'h44332211); wr(5'd17, 32'h88776655);
    wr(5'd2, 32'hAB123456);
    wr(5'd1, 32'h2 | 32'h4 | (1 << 4) | (5 << 8) | (1 << 14));
    waitDone();
    expQ = '{8'h06}; chkFrame("R7 prefix frame");
    expQ = '{8'h02, 8'h12, 8'h34, 8'h56, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    chkFrame("R4 R5 write frame");
    check("R7 two frames in window", lastWin, 2);

    // R6: erase with address, no data phase
    wr(5'd2, 32'h00010000);
    wr(5'd1, 32'h2 | (3 << 4));
    waitDone();
    expQ = '{8'h20, 8'h01, 8'h00, 8'h00}; chkFrame("R6 erase frame");

    // R3: write without address, no data
    wr(5'd1, 32'h2 | (2 << 4));
    waitDone();
    expQ = '{8'h06}; chkFrame("R3 wren frame");

    // R5 lower bound: 1 byte read with address
    wr(5'd2, 32'h00FFFFFE);
    wr(5'd1, 32'h2 | (0 << 4) | (0 << 8) | (1 << 14));
    waitDone();
    expQ = '{8'h03, 8'hFF, 8'hFF, 8'hFE, 8'h00}; chkFrame("R5 one byte read frame");
    rd(5'd16, r); check("R5 one byte store", {24'd0, r[7:0]}, {24'd0, fb(4)});

    // R5 upper bound: 64 byte read
    wr(5'd2, 32'h0);
    wr(5'd1, 32'h2 | (63 << 8) | (1 << 14));
    waitDone();
    expQ = '{8'h03, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < 64; i++) expQ.push_back(8'h00);
    chkFrame("R5 64 byte read frame");
    bad = 0;
    for (int w = 0; w < 16; w++) begin
      rd(5'(16 + w), r);
      for (int b = 0; b < 4; b++) if (r[8*b +: 8] !== fb(4 + 4*w + b)) bad++;
    end
    check("R5 64 byte store mismatches", bad, 0);

    // R10: read type with data disabled
    wr(5'd1, 32'h2 | (4 << 4));
    repeat (60) @(negedge clk);
    rd(5'd0, r); check("R10 error set idle", r, 32'h8);
    check("R10 no frame", frameLens.size(), 0);
    wr(5'd0, 32'h8);
    rd(5'd0, r); check("R8 error w1c", r, 32'h0);

    // R9: go while busy
    for (int w = 0; w < 16; w++) wr(5'(16 + w), {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    wr(5'd2, 32'h00000400);
    wr(5'd1, 32'h2 | (1 << 4) | (63 << 8) | (1 << 14));
    repeat (50) @(negedge clk);
    wr(5'd1, 32'h2 | (2 << 4));
    rd(5'd0, r); check("R9 error while busy", r, 32'h9);
    waitDone();
    expQ = '{8'h02, 8'h00, 8'h04, 8'h00};
    for (int i = 0; i < 64; i++) expQ.push_back(8'(i));
    chkFrame("R9 running frame intact");
    repeat (40) @(negedge clk);
    check("R9 no extra frame", frameLens.size(), 0);
    wr(5'd0, 32'h8);

    // R11: lockdown
    wr(5'd0, 32'h8000);
    rd(5'd0, r); check("R11 lock bit", r, 32'h8000);
    wr(5'd5, 32'hFFFFFFFF); wr(5'd4, 32'h0); wr(5'd3, 32'h99);
    rd(5'd5, r); check("R11 menu frozen", r, 32'h20060203);
    rd(5'd4, r); check("R11 types frozen", r, 32'h50DE);
    rd(5'd3, r); check("R11 prefix frozen", r, 32'h06);
    wr(5'd2, 32'h00ABCDEF);
    rd(5'd2, r); check("R11 address writable", r, 32'h00ABCDEF);
    wr(5'd1, 32'h2 | 32'h4 | (2 << 4));
    waitDone();
    expQ = '{8'h06}; chkFrame("R11 prefix on wire");
    expQ = '{8'h06}; chkFrame("R11 opcode on wire");

    check("R12 line idle and clock width errors", lineErr, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule